// File: doc/BRIEF.md
# Paired-Input Conditional Toggle Register

This block holds a two-bit state and, on every rising clock edge, inverts some of its bits depending on two single-bit request lines. Request line i is paired with state bit i. Sometimes no bit flips, sometimes one flips and sometimes both flip. The choice depends on how many requests are high. When exactly one request is high, it also depends on whether the two stored bits currently match.

The block is meant to sit behind logic that already presents clean, synchronous request levels. A clock-enable freezes the state without losing it. A synchronous active-low reset clears both bits and wins over the enable. The state bits are the outputs, driven straight from flip-flops.

Top module: `paired_toggle_reg`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, `q_o` becomes 2'b00 after that edge, whatever `en_i` and `req_i` are.
- R2: When `rst_n` is 1 and `en_i` is 0 at an edge, `q_o` keeps its value for every value of `req_i`.
- R3: With `en_i` high and `req_i` = 2'b11, both bits of `q_o` invert at the edge.
- R4: With `en_i` high and `req_i` = 2'b00, `q_o` keeps its value.
- R5: With `en_i` high, exactly one request high and `q_o[1]` equal to `q_o[0]`, only the bit paired with the low request inverts. For example, `req_i` = 2'b01 inverts `q_o[1]`.
- R6: With `en_i` high, exactly one request high and `q_o[1]` different from `q_o[0]`, only the bit paired with the high request inverts. For example, `req_i` = 2'b01 inverts `q_o[0]`.
- R7: The equality test uses the state held before the edge. From 2'b00, holding `req_i` = 2'b01 gives the sequence 00, 10, 11, 01, 00, and exactly one bit changes per edge.
- R8: Bit i of `req_i` is paired with bit i of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, clears the state |
| en_i | input | 1 | Update enable. When low, the state holds |
| req_i | input | 2 | Request lines. Bit i is paired with state bit i |
| q_o | output | 2 | Registered state bits |

## Verification
Every result appears one cycle after its stimulus, because only one register lies between `req_i`, `en_i` or `rst_n` and `q_o`. The bench sets the inputs, waits for exactly one rising edge and samples 1 ns later, so the checked value always belongs to the edge just taken. A table covers all four request patterns from each of the four start states. Each start state is reached from reset by repeating request 2'b01, so every row also exercises the stepping walk.

// File: rtl/ptr_pkg.sv
// Package: shared types and constants for the paired toggle register.
// Assumes a fixed pair of request/state bits; width is not a free choice.
package ptr_pkg;
    localparam int unsigned PAIR_W = 2;

    typedef logic [PAIR_W-1:0] pair_t;

    // How many request lines are active this cycle.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_ONE  = 2'd1,
        REQ_BOTH = 2'd2
    } req_count_e;

    localparam pair_t CLEAR_STATE = '0;
endpackage

// File: rtl/ptr_decide.sv
// Module: ptr_decide
// Computes which state bits to invert from the requests and the state
// held before the edge. Purely combinational. Assumes the requests are
// already synchronous to the clock.
module ptr_decide
    import ptr_pkg::*;
(
    input  pair_t req_i,
    input  pair_t cur_q_i,
    output pair_t flip_o
);
    req_count_e cnt;
    logic       same;

    // Classify the request pattern by the number of active lines.
    always_comb begin
        unique case (req_i)
            2'b00:   cnt = REQ_NONE;
            2'b11:   cnt = REQ_BOTH;
            default: cnt = REQ_ONE;
        endcase
    end

    // Equality of the held state bits.
    always_comb begin
        same = (cur_q_i[1] == cur_q_i[0]);
    end

    // Select the inversion mask; with one request the mask names either
    // the low line (state equal) or the high line (state different).
    always_comb begin
        unique case (cnt)
            REQ_BOTH: flip_o = 2'b11;
            REQ_ONE:  flip_o = same ? ~req_i : req_i;
            default:  flip_o = 2'b00;
        endcase
    end

    // R7: never more bits flagged than active requests allow
    always_comb begin
        flip_cnt_chk: assert ($countones(flip_o) <= $countones(req_i))
            else $error("flip mask wider than request count");
    end
endmodule

// File: rtl/ptr_state_reg.sv
// Module: ptr_state_reg
// Holds the state pair. Synchronous active-low clear beats the enable;
// when enabled, the bits named in the mask are inverted.
module ptr_state_reg
    import ptr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  pair_t flip_i,
    output pair_t q_o
);
    // State update: clear, hold, or apply the inversion mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= CLEAR_STATE;
        else if (en_i)
            q_o <= q_o ^ flip_i;
    end

    // R1
    clear_chk: assert property (@(posedge clk) !rst_n |=> q_o == 2'b00);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en_i) |=> $stable(q_o));
endmodule

// File: rtl/paired_toggle_reg.sv
// Module: paired_toggle_reg (top)
// Two-bit conditional toggle register. Request i is paired with state
// bit i. Assumes clean synchronous inputs; outputs come from flops.
module paired_toggle_reg
    import ptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] req_i,
    output logic [1:0] q_o
);
    pair_t flip;
    pair_t state;

    ptr_decide u_decide (
        .req_i   (req_i),
        .cur_q_i (state),
        .flip_o  (flip)
    );

    ptr_state_reg u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .flip_i (flip),
        .q_o    (state)
    );

    // Drive the outputs from the state flops.
    always_comb q_o = state;

    // R3
    both_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && req_i == 2'b11) |=> q_o == ~$past(q_o));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && req_i == 2'b00) |=> $stable(q_o));

    // R5
    eq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $countones(req_i) == 1 && q_o[0] == q_o[1])
        |=> (q_o ^ $past(q_o)) == ~$past(req_i));

    // R6
    ne_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $countones(req_i) == 1 && q_o[0] != q_o[1])
        |=> (q_o ^ $past(q_o)) == $past(req_i));

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $countones(req_i) == 1) |=> $countones(q_o ^ $past(q_o)) == 1);
endmodule

// File: tb/tb_paired_toggle_reg.sv
// Bench: table walk over every request pattern from every state, then
// directed reset, enable and sequence checks.
module tb_paired_toggle_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] req_i = 2'b00;
    logic [1:0] q_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    paired_toggle_reg dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .req_i (req_i),
        .q_o   (q_o)
    );

    // Each entry: {start state, request, expected next state}.
    localparam logic [5:0] VEC [16] = '{
        {2'b00, 2'b00, 2'b00}, {2'b00, 2'b01, 2'b10},
        {2'b00, 2'b10, 2'b01}, {2'b00, 2'b11, 2'b11},
        {2'b01, 2'b00, 2'b01}, {2'b01, 2'b01, 2'b00},
        {2'b01, 2'b10, 2'b11}, {2'b01, 2'b11, 2'b10},
        {2'b10, 2'b00, 2'b10}, {2'b10, 2'b01, 2'b11},
        {2'b10, 2'b10, 2'b00}, {2'b10, 2'b11, 2'b01},
        {2'b11, 2'b00, 2'b11}, {2'b11, 2'b01, 2'b01},
        {2'b11, 2'b10, 2'b10}, {2'b11, 2'b11, 2'b00}
    };

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (q_o !== exp) begin
            fails++;
            $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
        end
    endtask

    // One edge with the given inputs, sampled 1 ns after the edge.
    task automatic step(input logic r, input logic e, input logic [1:0] rq);
        rst_n = r; en_i = e; req_i = rq;
        @(posedge clk); #1;
    endtask

    // Reach a start state from reset by repeating request 01.
    task automatic go_to(input logic [1:0] s);
        int n;
        n = (s == 2'b00) ? 0 : (s == 2'b10) ? 1 : (s == 2'b11) ? 2 : 3;
        step(1'b0, 1'b1, 2'b11);
        for (int k = 0; k < n; k++) step(1'b1, 1'b1, 2'b01);
    endtask

    initial begin
        step(1'b0, 1'b0, 2'b00);
        check("R1 reset state", 2'b00);

        for (int i = 0; i < 16; i++) begin
            go_to(VEC[i][5:4]);
            check("R8 start state reached", VEC[i][5:4]);
            step(1'b1, 1'b1, VEC[i][3:2]);
            check($sformatf("R3/R4/R5/R6 row %0d", i), VEC[i][1:0]);
        end

        // R7: pre-edge equality drives a four-step cycle.
        go_to(2'b00);
        step(1'b1, 1'b1, 2'b01); check("R7 step1", 2'b10);
        step(1'b1, 1'b1, 2'b01); check("R7 step2", 2'b11);
        step(1'b1, 1'b1, 2'b01); check("R7 step3", 2'b01);
        step(1'b1, 1'b1, 2'b01); check("R7 step4", 2'b00);
        step(1'b1, 1'b1, 2'b10); check("R7 req10 from 00", 2'b01);
        step(1'b1, 1'b1, 2'b10); check("R7 req10 from 01", 2'b11);

        // R2: enable low holds for every request pattern.
        for (int r = 0; r < 4; r++) begin
            step(1'b1, 1'b0, 2'(r));
            check("R2 enable low hold", 2'b11);
        end

        // R4: repeated idle keeps state.
        step(1'b1, 1'b1, 2'b00); check("R4 idle hold", 2'b11);
        step(1'b1, 1'b1, 2'b00); check("R4 idle hold again", 2'b11);

        // R1: reset wins over enable with active requests.
        go_to(2'b10);
        step(1'b0, 1'b1, 2'b11); check("R1 reset over enable", 2'b00);
        step(1'b0, 1'b0, 2'b01); check("R1 reset with enable low", 2'b00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule